// File: doc/BRIEF.md
# Row-Column Transform Phase Sequencer

This block schedules one transform of length N = Nr x Nc on a separate arithmetic datapath that has a column-DFT array and a twiddle multiplier. A transform runs as up to three phases in fixed order. The first phase runs the column DFTs of length Nr. The second is the twiddle multiplication. The last runs the row DFTs of length Nc. In every busy cycle the block drives a phase code, an outer index (column or row slot), an inner step index, a read strobe and read address, and a write strobe and write address. The write stream is the read stream delayed by the latency of the datapath.

The factors are given in units of 16, so Nr = 16 x `nr_units` and Nc = 16 x `nc_units`, and N is always a multiple of 256. A mode input selects a 2-D transform, which leaves out the twiddle phase. A pruning input sets how many row-DFT slots run. Fewer slots shorten the row phase in proportion. The block latches its configuration when it accepts `start`, raises `busy` for the whole schedule, and then gives a one-cycle `done` pulse.

Top module: `fft_rc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are 0 and `phase` is 0 (idle).
- R2: `start` is accepted only while idle, and only if `nr_units` is in 1..MAX_NR/16 and `nc_units` is in 1..MAX_NC/16. Any other start leaves the block idle.
- R3: The column phase (`phase`=1) comes first. It lasts Nr*Nc/4 cycles, with `major_idx` counting columns 0..Nc-1 and, within each column, `minor_idx` counting 0..Nr/4-1.
- R4: In 1-D mode (`mode_2d`=0), the twiddle phase (`phase`=2) follows. It lasts 4*Nc cycles, with `major_idx` 0..Nc-1 and `minor_idx` 0..3 within each.
- R5: In 2-D mode (`mode_2d`=1), the row phase directly follows the column phase and `phase` is never 2.
- R6: The row phase (`phase`=3) is last. It runs K row slots of Nc/4 cycles each, with `major_idx` 0..K-1 and `minor_idx` 0..Nc/4-1. K equals `prune_rows` when that is in 1..Nc-1 and equals Nc otherwise, so the full row phase takes Nc*Nc/4 cycles.
- R7: `rd_en` is high in every busy cycle. `rd_addr` is 0 in the first cycle of each phase and rises by one in each later cycle of that phase.
- R8: `wr_en` and `wr_addr` repeat `rd_en` and `rd_addr` exactly LAT cycles later.
- R9: `busy` rises in the cycle after acceptance and stays high through the last row cycle. `done` is high for exactly the next cycle, with `busy` low.
- R10: Configuration inputs and `start` have no effect while busy. The running schedule continues with the values latched at acceptance.
- R11: A valid `start` given in the cycle in which `done` is high is accepted, and the next schedule begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a transform |
| nr_units | input | $clog2(MAX_NR/16+1) | Nr divided by 16 |
| nc_units | input | $clog2(MAX_NC/16+1) | Nc divided by 16 |
| mode_2d | input | 1 | 1 selects a 2-D transform (twiddle phase left out) |
| prune_rows | input | $clog2(MAX_NC+1) | Requested row-slot count; 0 or at least Nc means all |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle completion pulse |
| phase | output | 2 | 0 idle, 1 column, 2 twiddle, 3 row |
| major_idx | output | $clog2(MAX_NC) | Column or row-slot index |
| minor_idx | output | $clog2(max(MAX_NR,MAX_NC)/4) | Step within the current column or row slot |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | $clog2(max(MAX_NR,MAX_NC)*MAX_NC/4) | Phase-local read address |
| wr_en | output | 1 | Write strobe, LAT cycles after read |
| wr_addr | output | same as rd_addr | Write address, LAT cycles after read |

## Verification
Two functions can fall in the same cycle: the `done` pulse that ends one schedule, and the acceptance of the next `start`. The bench raises `start` in exactly the cycle where it sees `done`. It then expects the full column sequence to begin in the next cycle, with no idle gap. Meanwhile the write stream of the earlier run is still draining. A second collision is a `start` with changed configuration in the middle of a run. The bench judges this by requiring the cycle-by-cycle sequence of the original configuration to stay intact.

// File: rtl/fft_rc_seq_pkg.sv
// Shared types for the row-column transform sequencer.
// Phase encoding is visible at the top-level port and is fixed.
package fft_rc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COL  = 2'd1,
        PH_TWID = 2'd2,
        PH_ROW  = 2'd3
    } phase_e;
endpackage

// File: rtl/fft_rc_cfg.sv
// Configuration capture. Checks a start request for legal factors and, on
// acceptance, latches the factors, the mode and the effective row-slot count.
// Assumes the caller gives 'idle' high only when no schedule is running.
module fft_rc_cfg #(
    parameter int MAX_NR = 64,
    parameter int MAX_NC = 64,
    localparam int NRU_MAX = MAX_NR / 16,
    localparam int NCU_MAX = MAX_NC / 16,
    localparam int NRU_W   = $clog2(NRU_MAX + 1),
    localparam int NCU_W   = $clog2(NCU_MAX + 1),
    localparam int ROWS_W  = $clog2(MAX_NC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              idle,
    input  logic [NRU_W-1:0]  nr_units,
    input  logic [NCU_W-1:0]  nc_units,
    input  logic              mode_2d,
    input  logic [ROWS_W-1:0] prune_rows,
    output logic              accept,
    output logic [NRU_W-1:0]  nr_l,
    output logic [NCU_W-1:0]  nc_l,
    output logic              twod_l,
    output logic [ROWS_W-1:0] rows_l
);
    logic              legal;
    logic [ROWS_W-1:0] nc_full;
    logic [ROWS_W-1:0] rows_eff;

    // Legality of the requested factors.
    always_comb begin
        legal = (nr_units != '0) && (int'(nr_units) <= NRU_MAX) &&
                (nc_units != '0) && (int'(nc_units) <= NCU_MAX);
    end

    assign accept = start && idle && legal;

    // Effective row-slot count: out-of-range requests mean "all slots".
    always_comb begin
        nc_full  = ROWS_W'(16 * int'(nc_units));
        rows_eff = nc_full;
        if ((prune_rows != '0) && (prune_rows < nc_full))
            rows_eff = prune_rows;
    end

    // Hold configuration from acceptance to the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nr_l   <= '0;
            nc_l   <= '0;
            twod_l <= 1'b0;
            rows_l <= '0;
        end else if (accept) begin
            nr_l   <= nr_units;
            nc_l   <= nc_units;
            twod_l <= mode_2d;
            rows_l <= rows_eff;
        end
    end
endmodule

// File: rtl/fft_rc_phase_fsm.sv
// Phase state machine. Steps column -> (twiddle) -> row -> idle. Each move
// happens on the step counter's 'last' flag. Gives a registered done pulse.
// Assumes 'last' is meaningful only while not idle.
module fft_rc_phase_fsm
    import fft_rc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   twod,
    input  logic   last,
    output phase_e phase,
    output logic   done
);
    phase_e nxt;

    // Next-phase selection.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (accept) nxt = PH_COL;
            PH_COL:  if (last)   nxt = twod ? PH_ROW : PH_TWID;
            PH_TWID: if (last)   nxt = PH_ROW;
            PH_ROW:  if (last)   nxt = PH_IDLE;
            default:             nxt = PH_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= (phase == PH_ROW) && last;
        end
    end
endmodule

// File: rtl/fft_rc_step_ctr.sv
// Nested step counter: the inner (minor) count runs inside the outer (major)
// count, with a linear count alongside. All counts clear while inactive and
// wrap to zero on the final step of a phase. Assumes both lengths are >= 1.
module fft_rc_step_ctr #(
    parameter int MIN_W  = 4,
    parameter int MAJ_W  = 6,
    parameter int ADDR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [MIN_W:0]   len_minor,
    input  logic [MAJ_W:0]   len_major,
    output logic [MIN_W-1:0] minor,
    output logic [MAJ_W-1:0] major,
    output logic [ADDR_W-1:0] lin,
    output logic             last
);
    logic minor_end;

    // End-of-inner and end-of-phase detection.
    always_comb begin
        minor_end = ({1'b0, minor} == (len_minor - 1'b1));
        last      = minor_end && ({1'b0, major} == (len_major - 1'b1));
    end

    // Advance, wrap at phase end, clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || last) begin
            minor <= '0;
            major <= '0;
            lin   <= '0;
        end else begin
            lin <= lin + 1'b1;
            if (minor_end) begin
                minor <= '0;
                major <= major + 1'b1;
            end else begin
                minor <= minor + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fft_rc_wr_delay.sv
// Write-side alignment: delays the read strobe and address by LAT cycles to
// match the datapath latency. LAT = 0 gives a straight wire.
module fft_rc_wr_delay #(
    parameter int LAT    = 3,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_en,
    output logic [ADDR_W-1:0] out_addr
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_en   = in_en;
            assign out_addr = in_addr;
        end else begin : g_pipe
            logic [LAT-1:0]    en_sr;
            logic [ADDR_W-1:0] addr_sr [LAT];

            // Shift strobe and address through LAT stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_sr <= '0;
                    for (int i = 0; i < LAT; i++) addr_sr[i] <= '0;
                end else begin
                    en_sr[0]   <= in_en;
                    addr_sr[0] <= in_addr;
                    for (int i = 1; i < LAT; i++) begin
                        en_sr[i]   <= en_sr[i-1];
                        addr_sr[i] <= addr_sr[i-1];
                    end
                end
            end
            assign out_en   = en_sr[LAT-1];
            assign out_addr = addr_sr[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/fft_rc_seq.sv
// Row-column transform phase sequencer, top level. Accepts a start, latches
// the configuration, and steps column, twiddle (1-D only) and row phases.
// Each cycle it drives indices and a read/write address stream.
// Assumes MAX_NR and MAX_NC are multiples of 16.
module fft_rc_seq
    import fft_rc_seq_pkg::*;
#(
    parameter int MAX_NR = 64,
    parameter int MAX_NC = 64,
    parameter int LAT    = 3,
    localparam int MAX_D  = (MAX_NR > MAX_NC) ? MAX_NR : MAX_NC,
    localparam int NRU_W  = $clog2(MAX_NR / 16 + 1),
    localparam int NCU_W  = $clog2(MAX_NC / 16 + 1),
    localparam int ROWS_W = $clog2(MAX_NC + 1),
    localparam int MAJ_W  = $clog2(MAX_NC),
    localparam int MIN_W  = $clog2(MAX_D / 4),
    localparam int ADDR_W = $clog2(MAX_D * MAX_NC / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NRU_W-1:0]  nr_units,
    input  logic [NCU_W-1:0]  nc_units,
    input  logic              mode_2d,
    input  logic [ROWS_W-1:0] prune_rows,
    output logic              busy,
    output logic              done,
    output logic [1:0]        phase,
    output logic [MAJ_W-1:0]  major_idx,
    output logic [MIN_W-1:0]  minor_idx,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    phase_e            ph;
    logic              accept;
    logic [NRU_W-1:0]  nr_l;
    logic [NCU_W-1:0]  nc_l;
    logic              twod_l;
    logic [ROWS_W-1:0] rows_l;
    logic [MIN_W:0]    len_minor;
    logic [MAJ_W:0]    len_major;
    logic              last;

    fft_rc_cfg #(.MAX_NR(MAX_NR), .MAX_NC(MAX_NC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .start(start), .idle(ph == PH_IDLE),
        .nr_units(nr_units), .nc_units(nc_units), .mode_2d(mode_2d),
        .prune_rows(prune_rows), .accept(accept), .nr_l(nr_l), .nc_l(nc_l),
        .twod_l(twod_l), .rows_l(rows_l)
    );

    fft_rc_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .twod(twod_l),
        .last(last), .phase(ph), .done(done)
    );

    // Per-phase inner and outer lengths.
    always_comb begin
        len_minor = (MIN_W+1)'(1);
        len_major = (MAJ_W+1)'(1);
        unique case (ph)
            PH_COL: begin
                len_minor = (MIN_W+1)'(4 * int'(nr_l));
                len_major = (MAJ_W+1)'(16 * int'(nc_l));
            end
            PH_TWID: begin
                len_minor = (MIN_W+1)'(4);
                len_major = (MAJ_W+1)'(16 * int'(nc_l));
            end
            PH_ROW: begin
                len_minor = (MIN_W+1)'(4 * int'(nc_l));
                len_major = (MAJ_W+1)'(rows_l);
            end
            default: ;
        endcase
    end

    fft_rc_step_ctr #(.MIN_W(MIN_W), .MAJ_W(MAJ_W), .ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .active(ph != PH_IDLE),
        .len_minor(len_minor), .len_major(len_major),
        .minor(minor_idx), .major(major_idx), .lin(rd_addr), .last(last)
    );

    assign busy  = (ph != PH_IDLE);
    assign rd_en = busy;
    assign phase = ph;

    fft_rc_wr_delay #(.LAT(LAT), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_en(rd_en), .in_addr(rd_addr),
        .out_en(wr_en), .out_addr(wr_addr)
    );
endmodule

// File: rtl/fft_rc_seq_chk.sv
// Port-level temporal checks for the sequencer, bound to every instance.
module fft_rc_seq_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] rd_addr
);
    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done follows the final busy cycle, with busy low
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R1: idle phase code whenever not busy
    a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (phase == 2'd0));
    // R3: column phase is left only toward twiddle or row
    a_r3_col_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |=> (phase != 2'd0));
    // R4: twiddle phase is left only toward row
    a_r4_twid_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd3));
    // R6: row phase is left only toward idle
    a_r6_row_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |=> (phase == 2'd3 || phase == 2'd0));
    // R7: address rises by one inside a phase
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && phase == $past(phase)) |->
        (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));
    // R7: address restarts at each phase entry
    a_r7_addr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != $past(phase)) |-> (rd_addr == '0));
endmodule

bind fft_rc_seq fft_rc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .phase(phase), .rd_addr(rd_addr)
);

// File: tb/fft_rc_seq_bench.sv
module fft_rc_seq_bench;
    localparam int MAX_NR = 32;
    localparam int MAX_NC = 32;
    localparam int LAT    = 2;
    localparam int AW     = $clog2(32 * 32 / 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  nr_units = '0;
    logic [1:0]  nc_units = '0;
    logic        mode_2d = 1'b0;
    logic [5:0]  prune_rows = '0;
    logic        busy, done, rd_en, wr_en;
    logic [1:0]  phase;
    logic [4:0]  major_idx;
    logic [2:0]  minor_idx;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0;
    int bad = 0;
    int exp_ph [1024];
    int exp_maj[1024];
    int exp_min[1024];
    int exp_lin[1024];
    int exp_n;

    always #10 clk = ~clk;

    fft_rc_seq #(.MAX_NR(MAX_NR), .MAX_NC(MAX_NC), .LAT(LAT)) u_fft_rc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .nr_units(nr_units),
        .nc_units(nc_units), .mode_2d(mode_2d), .prune_rows(prune_rows),
        .busy(busy), .done(done), .phase(phase), .major_idx(major_idx),
        .minor_idx(minor_idx), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            if (bad <= 20) $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Expected schedule computed from the requirement formulas.
    task automatic build(input int nru, input int ncu, input bit twod, input int prune);
        int nr = 16 * nru;
        int nc = 16 * ncu;
        int rows = (prune == 0 || prune >= nc) ? nc : prune;
        int t = 0;
        for (int c = 0; c < nc; c++)
            for (int s = 0; s < nr / 4; s++) begin
                exp_ph[t] = 1; exp_maj[t] = c; exp_min[t] = s; exp_lin[t] = c * (nr / 4) + s; t++;
            end
        if (!twod)
            for (int c = 0; c < nc; c++)
                for (int s = 0; s < 4; s++) begin
                    exp_ph[t] = 2; exp_maj[t] = c; exp_min[t] = s; exp_lin[t] = c * 4 + s; t++;
                end
        for (int r = 0; r < rows; r++)
            for (int s = 0; s < nc / 4; s++) begin
                exp_ph[t] = 3; exp_maj[t] = r; exp_min[t] = s; exp_lin[t] = r * (nc / 4) + s; t++;
            end
        exp_n = t;
    endtask

    function automatic string ph_tag(input int p);
        return (p == 1) ? "R3 column" : (p == 2) ? "R4 twiddle" : "R6 row";
    endfunction

    // Runs one schedule and compares every cycle against the model.
    task automatic run(input int nru, input int ncu, input bit twod, input int prune,
                       input bit pre_started, input bit chain, input bit disturb);
        build(nru, ncu, twod, prune);
        if (!pre_started) begin
            @(negedge clk);
            nr_units = 2'(nru); nc_units = 2'(ncu); mode_2d = twod; prune_rows = 6'(prune);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < exp_n; t++) begin
            if (disturb && t == 5) begin
                start = 1'b1; nr_units = 2'(3 - nru); mode_2d = ~twod; prune_rows = 6'd1;
            end
            if (disturb && t == 6) start = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R9 busy during run", int'(busy), 1);
            chk(int'(phase) == exp_ph[t], disturb ? "R10 phase" : ph_tag(exp_ph[t]), int'(phase), exp_ph[t]);
            chk(int'(major_idx) == exp_maj[t], ph_tag(exp_ph[t]), int'(major_idx), exp_maj[t]);
            chk(int'(minor_idx) == exp_min[t], ph_tag(exp_ph[t]), int'(minor_idx), exp_min[t]);
            chk(rd_en === 1'b1 && int'(rd_addr) == exp_lin[t], "R7 read", int'(rd_addr), exp_lin[t]);
            if (twod && t == (16 * nru) * (16 * ncu) / 4)
                chk(int'(phase) == 3, "R5 twiddle skipped", int'(phase), 3);
            if (t >= LAT)
                chk(wr_en === 1'b1 && int'(wr_addr) == exp_lin[t - LAT], "R8 write", int'(wr_addr), exp_lin[t - LAT]);
            @(negedge clk);
        end
        chk(done === 1'b1 && busy === 1'b0 && phase == 2'd0, "R9 done pulse", int'(done), 1);
        if (chain) begin
            nr_units = 2'(nru); nc_units = 2'(ncu); mode_2d = twod; prune_rows = 6'(prune);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end else begin
            for (int t = exp_n; t < exp_n + LAT; t++) begin
                chk(wr_en === 1'b1 && int'(wr_addr) == exp_lin[t - LAT], "R8 write drain", int'(wr_addr), exp_lin[t - LAT]);
                @(negedge clk);
            end
            chk(wr_en === 1'b0 && done === 1'b0 && busy === 1'b0, "R9 quiet after done", int'(done), 0);
        end
    endtask

    task automatic bad_start(input int nru, input int ncu);
        @(negedge clk);
        nr_units = 2'(nru); nc_units = 2'(ncu); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(busy === 1'b0 && phase == 2'd0, "R2 illegal start ignored", int'(busy), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        bad++; checks++;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int prunes[6] = '{0, 1, 3, 31, 32, 40};
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0 && phase == 2'd0,
            "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && phase == 2'd0, "R1 idle after reset", int'(phase), 0);
        bad_start(0, 1);
        bad_start(1, 0);
        bad_start(3, 1);
        bad_start(2, 3);
        for (int a = 1; a <= 2; a++)
            for (int b = 1; b <= 2; b++)
                for (int m = 0; m < 2; m++)
                    for (int p = 0; p < 6; p++)
                        run(a, b, m[0], prunes[p], 1'b0, 1'b0, 1'b0);
        // R10: mid-run start and config change are ignored
        run(2, 1, 1'b0, 0, 1'b0, 1'b0, 1'b1);
        // R11: start in the done cycle chains straight into the next run
        run(1, 2, 1'b1, 3, 1'b0, 1'b1, 1'b0);
        run(1, 2, 1'b1, 3, 1'b1, 1'b0, 1'b0);
        chk(busy === 1'b0, "R11 chained run finished", int'(busy), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule